// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Flags

This block provides two reloadable 8-bit interval timers for the host side of a sound controller. The host programs it with register writes, each carrying a register index and a data byte. Two indices hold the reload counts of the timers. A third index is a control register. A control write either wipes every pending flag, or it stores a run/mask byte that starts or stops each timer, masks each timer's flag and clears selected flags.

The block does not generate its own time base. Each timer advances only on a one-cycle tick strobe that logic outside the block produces. A timer configured with count `c` overflows once every `256 - c` ticks and then reloads by itself. An unmasked overflow latches a sticky flag. The interrupt output is high while any flag is pending. A status byte shows the flags and the interrupt state in a single read.

Top module: `dual_interval_timer`

## Requirements
- R1: While reset is asserted, and after it is released with no write, status_o is 0x00 and irq_o is 0. Both timers are stopped and the run/mask byte is 0x00.
- R2: Register index 2 holds the count of timer A and index 3 holds the count of timer B. From a restart with count c, the timer overflows on the (256 - c)-th tick it receives while running. Count 0xFF gives an overflow on every tick.
- R3: On overflow the timer reloads from its count register and keeps running with the same period. No host action is needed.
- R4: A write to index 4 with data bit 7 set clears both flags. It changes neither the run/mask byte nor the timer counters.
- R5: A write to index 4 with data bit 7 clear stores the byte as the run/mask byte, where bit 0 runs timer A and bit 1 runs timer B. A run bit that goes 0 to 1 restarts that timer from its count. A run bit that goes 1 to 0 stops it, and a stopped timer ignores ticks. A run bit that is written with its current value leaves the timer's phase unchanged.
- R6: An overflow of timer A sets flag A (status bit 6) unless run/mask bit 6 is 1. An overflow of timer B sets flag B (status bit 5) unless run/mask bit 5 is 1.
- R7: A write to index 4 with bit 7 clear clears flag A if data bit 6 is 1 and flag B if data bit 5 is 1. Otherwise a flag stays set until it is cleared.
- R8: status_o bit 7 equals irq_o, bit 6 is flag A, bit 5 is flag B and bits 4..0 read 0. irq_o is 1 exactly when a flag is set.
- R9: Writing a count to a running timer restarts that timer from the new count. Writing a count to a stopped timer only stores the value.
- R10: Writes to any index other than 2, 3 and 4 have no effect.
- R11: If an unmasked overflow occurs in the same cycle as a write that clears its flag, the flag ends up set. If a restart and a tick for the same timer occur in the same cycle, the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register index of the write |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 2 | Per-timer tick strobe: bit 0 timer A, bit 1 timer B |
| status_o | output | 8 | Status byte: interrupt state and flags |
| irq_o | output | 1 | Interrupt request, high while a flag is pending |

## Verification
The hardest cases to reach are a timer's final tick landing in the same cycle as a flag-clearing control write, and a restart colliding with a tick. The ports never show a counter's phase, so the bench must place these events blind. The directed part restarts a timer with a short period and counts ticks from that restart, so the bench knows the exact overflow cycle and can put the colliding write there. The random part keeps counts near 0xFF so overflows are frequent. It compares every cycle against a tick-count model, so chance collisions with writes, masks and restarts are also checked.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned NUM_TMR     = 2;
  localparam int unsigned IRQ_BIT     = DATA_W - 1;
  localparam int unsigned CLR_ALL_BIT = DATA_W - 1;
  // timer t: flag, mask and flag-clear bit at FLAG_TOP - t
  localparam int unsigned FLAG_TOP    = DATA_W - 2;

  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/dit_regfile.sv
module dit_regfile
  import dit_pkg::*;
#(
  parameter int unsigned CNT_IDX0 = 2,
  parameter int unsigned CTL_IDX  = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [DATA_W-1:0]                en_o,
  output logic [NUM_TMR-1:0]               run_o,
  output logic [NUM_TMR-1:0]               mask_o,
  output logic [NUM_TMR-1:0]               restart_o,
  output logic [NUM_TMR-1:0]               stop_o,
  output logic [NUM_TMR-1:0]               clr_o,
  output logic [NUM_TMR-1:0][DATA_W-1:0]   load_o
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_IDX);

  logic [DATA_W-1:0]              en_q;
  logic [NUM_TMR-1:0][DATA_W-1:0] cnt_q;
  logic ctl_wr, clr_all, en_wr;

  assign ctl_wr  = wr_en_i && (wr_addr_i == CTL_A);
  assign clr_all = ctl_wr && wr_data_i[CLR_ALL_BIT];
  assign en_wr   = ctl_wr && !wr_data_i[CLR_ALL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_wr) en_q <= wr_data_i;
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_IDX0 + t);
    localparam int unsigned       FP    = FLAG_TOP - t;
    logic cnt_wr;

    assign cnt_wr = wr_en_i && (wr_addr_i == CNT_A);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q[t] <= '0;
      else if (cnt_wr) cnt_q[t] <= wr_data_i;
    end

    assign run_o[t]     = en_q[t];
    assign mask_o[t]    = en_q[FP];
    // restart on run-bit rise or on count write while running
    assign restart_o[t] = (en_wr && wr_data_i[t] && !en_q[t]) || (cnt_wr && en_q[t]);
    assign stop_o[t]    = en_wr && !wr_data_i[t] && en_q[t];
    assign clr_o[t]     = clr_all || (en_wr && wr_data_i[FP]);
    assign load_o[t]    = cnt_wr ? wr_data_i : cnt_q[t];
  end

  assign en_o = en_q;
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  // restart and stop take priority over a tick in the same cycle
  assign adv   = run_i && tick_i && !restart_i && !stop_i;
  assign ovf_o = adv && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || ovf_o) cnt_q <= load_i;
    else if (adv)               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dit_flags.sv
module dit_flags
  import dit_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_TMR-1:0] ovf_i,
  input  logic [NUM_TMR-1:0] mask_i,
  input  logic [NUM_TMR-1:0] clr_i,
  output logic [DATA_W-1:0]  status_o,
  output logic               irq_o
);
  logic [NUM_TMR-1:0] flag_q;

  // a new overflow wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | (ovf_i & ~mask_i);
  end

  assign irq_o = |flag_q;

  always_comb begin
    status_o = '0;
    for (int t = 0; t < NUM_TMR; t++) status_o[FLAG_TOP-t] = flag_q[t];
    status_o[IRQ_BIT] = irq_o;
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int unsigned CNT_IDX0 = 2,
  parameter int unsigned CTL_IDX  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [NUM_TMR-1:0] tick_i,
  output logic [DATA_W-1:0]  status_o,
  output logic               irq_o
);
  logic [DATA_W-1:0]              en;
  logic [NUM_TMR-1:0]             run, mask, restart, stop, clr, ovf;
  logic [NUM_TMR-1:0][DATA_W-1:0] load;

  dit_regfile #(.CNT_IDX0(CNT_IDX0), .CTL_IDX(CTL_IDX)) regs_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .en_o     (en),
    .run_o    (run),
    .mask_o   (mask),
    .restart_o(restart),
    .stop_o   (stop),
    .clr_o    (clr),
    .load_o   (load)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_cnt
    dit_counter #(.CNT_W(DATA_W)) cnt_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run[t]),
      .restart_i(restart[t]),
      .stop_i   (stop[t]),
      .tick_i   (tick_i[t]),
      .load_i   (load[t]),
      .ovf_o    (ovf[t])
    );
  end

  dit_flags flags_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ovf_i   (ovf),
    .mask_i  (mask),
    .clr_i   (clr),
    .status_o(status_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
#(
  parameter int unsigned CTL_IDX = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [NUM_TMR-1:0] tick_i,
  input logic [DATA_W-1:0]  status_o,
  input logic               irq_o,
  input logic [DATA_W-1:0]  en_i,
  input logic [NUM_TMR-1:0] run_i,
  input logic [NUM_TMR-1:0] ovf_i
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_IDX);

  logic ctl_wr;
  assign ctl_wr = wr_en_i && (wr_addr_i == CTL_A);

  AST_CLR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && wr_data_i[CLR_ALL_BIT] && ovf_i == '0) |=> (status_o[FLAG_TOP] == 1'b0 && status_o[FLAG_TOP-1] == 1'b0)); // R4

  AST_MASK_A_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i[FLAG_TOP] && !status_o[FLAG_TOP]) |=> !status_o[FLAG_TOP]); // R6

  AST_FLAG_A_FROM_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[FLAG_TOP]) |-> $past(ovf_i[0])); // R6

  AST_FLAG_B_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[FLAG_TOP-1] && !ctl_wr) |=> status_o[FLAG_TOP-1]); // R7

  AST_STOPPED_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i[0] || !tick_i[0]) |-> !ovf_i[0]); // R5

  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status_o[FLAG_TOP] || status_o[FLAG_TOP-1])); // R8
endmodule

bind dual_interval_timer dit_checker #(.CTL_IDX(CTL_IDX)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .tick_i   (tick_i),
  .status_o (status_o),
  .irq_o    (irq_o),
  .en_i     (en),
  .run_i    (run),
  .ovf_i    (ovf)
);

// File: tb/dual_interval_timer_tb_top.sv
module dual_interval_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] data = '0;
  logic [1:0] tick = '0;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  dual_interval_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(addr),
    .wr_data_i(data), .tick_i(tick), .status_o(status), .irq_o(irq)
  );

  // reference model: remaining ticks until overflow
  logic [7:0] m_cnt [2];
  int         m_left [2];
  logic [7:0] m_en;
  logic [1:0] m_flag;

  function automatic logic [7:0] exp_status(logic [1:0] f);
    return {|f, f[0], f[1], 5'b0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt[0] <= '0; m_cnt[1] <= '0; m_left[0] <= 0; m_left[1] <= 0;
      m_en <= '0; m_flag <= '0;
    end else begin
      logic ctl, clr_all, en_wr;
      logic [1:0] nf;
      ctl     = we && addr == 8'd4;
      clr_all = ctl && data[7];
      en_wr   = ctl && !data[7];
      nf      = m_flag;
      if (clr_all) nf = '0;
      else if (en_wr) begin
        if (data[6]) nf[0] = 1'b0;
        if (data[5]) nf[1] = 1'b0;
      end
      for (int t = 0; t < 2; t++) begin
        logic cw, rs, sp, ov;
        cw = we && addr == 8'(2 + t);
        rs = (en_wr && data[t] && !m_en[t]) || (cw && m_en[t]);
        sp = en_wr && !data[t] && m_en[t];
        ov = m_en[t] && tick[t] && !rs && !sp && m_left[t] == 1;
        if (cw) m_cnt[t] <= data;
        if (rs) m_left[t] <= 256 - int'(cw ? data : m_cnt[t]);
        else if (ov) m_left[t] <= 256 - int'(m_cnt[t]);
        else if (m_en[t] && tick[t] && !sp) m_left[t] <= m_left[t] - 1;
        if (ov && !m_en[6-t]) nf[t] = 1'b1;
      end
      if (en_wr) m_en <= data;
      m_flag <= nf;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // continuous comparison against the model (R8 status layout, all rules)
  always @(negedge clk) begin
    if (cmp_on && rst_n && !done) begin
      chk("R8 status vs model", status, exp_status(m_flag));
      chk("R8 irq vs model", {7'b0, irq}, {7'b0, |m_flag});
    end
  end

  task automatic step(bit w, logic [7:0] a, logic [7:0] d, logic [1:0] tk);
    we = w; addr = a; data = d; tick = tk;
    @(negedge clk);
  endtask
  task automatic wr(logic [7:0] a, logic [7:0] d);
    step(1'b1, a, d, 2'b00);
  endtask
  task automatic ticks(logic [1:0] tk, int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, tk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1 status in reset", status, 8'h00);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    chk("R1 status after reset", status, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);

    // R2 period 256-c
    wr(8'd2, 8'hFC); wr(8'd4, 8'h01);
    ticks(2'b01, 3); chk("R2 no overflow before period", status, 8'h00);
    ticks(2'b01, 1); chk("R2 overflow at period", status, 8'hC0);
    chk("R8 irq with flag", {7'b0, irq}, 8'h01);
    ticks(2'b01, 4); chk("R7 flag sticky", status, 8'hC0);
    // R4 clear all keeps run state; R3 reload
    wr(8'd4, 8'h80); chk("R4 clear all", status, 8'h00);
    ticks(2'b01, 3); chk("R3 reload period", status, 8'h00);
    ticks(2'b01, 1); chk("R3 auto reload overflow", status, 8'hC0);
    // R7 selective clear, R6 mask
    wr(8'd4, 8'h41); chk("R7 clear by mask bit", status, 8'h00);
    ticks(2'b01, 4); chk("R6 masked overflow", status, 8'h00);
    // R5 unchanged run bit keeps phase
    wr(8'd4, 8'h01); ticks(2'b01, 2); wr(8'd4, 8'h01);
    ticks(2'b01, 1); chk("R5 no restart yet", status, 8'h00);
    ticks(2'b01, 1); chk("R5 phase kept", status, 8'hC0);
    // R5 stop and start
    wr(8'd4, 8'h80); wr(8'd4, 8'h00);
    ticks(2'b01, 10); chk("R5 stopped ignores ticks", status, 8'h00);
    wr(8'd4, 8'h01); ticks(2'b01, 3); chk("R5 restarted", status, 8'h00);
    ticks(2'b01, 1); chk("R5 restart period", status, 8'hC0);
    // R9 count write while running
    wr(8'd4, 8'h80); ticks(2'b01, 2); wr(8'd2, 8'hFE);
    ticks(2'b01, 1); chk("R9 running restart", status, 8'h00);
    ticks(2'b01, 1); chk("R9 new period", status, 8'hC0);
    // R9 count write while stopped
    wr(8'd4, 8'h80); wr(8'd4, 8'h00); wr(8'd2, 8'hFF);
    ticks(2'b01, 5); chk("R9 stopped stays stopped", status, 8'h00);
    wr(8'd4, 8'h01); ticks(2'b01, 1); chk("R9 count FF every tick", status, 8'hC0);
    // timer B
    wr(8'd4, 8'h80); wr(8'd3, 8'hFD); wr(8'd4, 8'h02);
    ticks(2'b11, 2); chk("R6 timer B pending", status, 8'h00);
    ticks(2'b11, 1); chk("R6 timer B flag", status, 8'hA0);
    wr(8'd4, 8'h22); chk("R7 clear flag B", status, 8'h00);
    ticks(2'b10, 6); chk("R6 timer B masked", status, 8'h00);
    // R10 other indices
    wr(8'h05, 8'hFF); wr(8'h00, 8'hFF); wr(8'h01, 8'h80); wr(8'hF9, 8'h3F);
    chk("R10 stray writes", status, 8'h00);
    wr(8'd4, 8'h00); wr(8'd4, 8'h02);
    ticks(2'b10, 2); chk("R10 count B intact", status, 8'h00);
    ticks(2'b10, 1); chk("R10 count B period", status, 8'hA0);
    // R11 overflow wins over clear
    wr(8'd4, 8'h00); wr(8'd4, 8'h02); ticks(2'b10, 2);
    step(1'b1, 8'd4, 8'h80, 2'b10); chk("R11 overflow beats clear", status, 8'hA0);
    // R11 restart beats tick
    wr(8'd4, 8'h80);
    step(1'b1, 8'd3, 8'hFD, 2'b10);
    ticks(2'b10, 2); chk("R11 tick dropped on restart", status, 8'h00);
    ticks(2'b10, 1); chk("R11 period after restart", status, 8'hA0);

    // random phase against model
    for (int i = 0; i < 5000; i++) begin
      logic [31:0] r;
      logic [7:0]  a, d;
      r = $urandom;
      if (r[3:0] == 4'd0) begin
        case (r[5:4])
          2'd0: begin a = 8'd2; d = 8'hF0 | 8'(r[11:8]); end
          2'd1: begin a = 8'd3; d = 8'hF0 | 8'(r[11:8]); end
          2'd2: begin a = 8'd4; d = (r[13:12] == 2'd0) ? 8'h80 : {1'b0, r[18:12]}; end
          default: begin a = r[23:16]; d = r[31:24]; end
        endcase
        step(1'b1, a, d, r[7:6]);
      end else begin
        step(1'b0, 8'h00, 8'h00, r[7:6]);
      end
    end

    step(1'b0, 8'h00, 8'h00, 2'b00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule